// File: doc/BRIEF.md
# Two-Level Page Translator with Associative Lookaside Cache

The block turns a 32-bit logical address into a physical address for a paged memory with 1 KB pages. The upper 22 bits of the address name the page and the low 10 bits are the byte within it. A small associative cache of recent translations is searched first, with every entry compared at once. When that search misses, a table walker reads two levels of page table from memory and then returns the result. The first-level table sits at an address given on the `ptbr` input. After a clean walk the walker places the new translation in the cache.

Each table entry is one 32-bit word. The entry's frame number is in bits 31:10, a present flag in bit 0 and a write-permission flag in bit 1. A request that names a non-present page faults. A write to a page whose write flag is clear also faults. The block takes one request at a time and accepts a new one only when idle. Memory reads use a valid/ready request channel and a response strobe, so the memory may stall for any number of cycles.

Top module: `pt_xlate`

## Requirements
- R1: The page number is `req_vaddr[31:10]` and the byte offset is `req_vaddr[9:0]`. A successful response carries `rsp_paddr = {frame, offset}`, and a faulting response carries `rsp_paddr = 0`.
- R2: When the page number matches a valid cache entry, `rsp_valid` pulses in the cycle after acceptance and no memory read is issued.
- R3: On a cache miss the first read goes to `ptbr + 4 * req_vaddr[31:20]`.
- R4: The second read goes to `{first-level entry[31:10], 10'b0} + 4 * req_vaddr[19:10]`.
- R5: If the first-level entry has bit 0 clear, the request faults after exactly one memory read and no second read is issued.
- R6: If the second-level entry has bit 0 clear, the request faults after two reads.
- R7: A write to a page whose entry has bit 1 clear faults, on both the cached path and the walk path. A read of the same page succeeds.
- R8: A walk that ends without a fault installs its translation, so the next access to that page hits. A walk that ends in a fault installs nothing, so the next access walks again.
- R9: The cache holds 8 translations. Refills take slots in round-robin order. After eight refills the ninth new page evicts the oldest one, and a flush does not move the round-robin pointer.
- R10: A one-cycle pulse on `flush` invalidates every cached translation, and a flush wins over a refill in the same cycle.
- R11: `req_ready` is high only while no request is in progress.
- R12: A memory read request stays asserted with a stable address until `mem_rd_ready` is seen, and any number of stall cycles gives the same result.
- R13: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, `mem_rd_valid` is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 32 | Byte address of the first-level table |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Request faulted |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
The bench targets several failure modes. A write to a read-only page that is already cached would pass if the cached path skipped the permission check. A faulting walk that still installed its translation would turn the next access into a silent hit. A missing first-level entry that still triggered a second read would show up as an extra read in the logged memory traffic. A round-robin pointer that skipped or restarted would evict the wrong page, and the revisit pattern after nine distinct refills exposes this. Random memory stalls and random page and offset mixes, including flushes, show whether the read address moves during a stall or whether the offset is dropped from the physical address.

// File: rtl/xl_pkg.sv
package xl_pkg;

  localparam int unsigned PTE_PRESENT_BIT = 0;
  localparam int unsigned PTE_WRITE_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OREQ  = 3'd1,
    ST_OWAIT = 3'd2,
    ST_IREQ  = 3'd3,
    ST_IWAIT = 3'd4,
    ST_FILL  = 3'd5,
    ST_RESP  = 3'd6
  } walk_state_e;

endpackage

// File: rtl/xl_tlb.sv
module xl_tlb #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VPN_W = 22,
  parameter int unsigned PFN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [VPN_W-1:0] vpn_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [DEPTH-1:0] wr_q;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] slot_sel;
  logic             fill_go;

  assign fill_go = fill_en && !flush;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign match[g]    = vld_q[g] && (vpn_q[g] == lk_vpn);
      assign slot_sel[g] = fill_go && (ptr_q == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (slot_sel[g]) begin
          vpn_q[g] <= fill_vpn;
          pfn_q[g] <= fill_pfn;
          wr_q[g]  <= fill_wr;
        end
      end
    end
  endgenerate

  always_comb begin
    lk_pfn = '0;
    lk_wr  = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match[k]) begin
        lk_pfn = lk_pfn | pfn_q[k];
        lk_wr  = lk_wr | wr_q[k];
      end
    end
  end

  assign lk_hit = |match;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_go) begin
      if (ptr_q == IDX_W'(DEPTH - 1)) ptr_d = '0;
      else                            ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      if (flush)        vld_q <= '0;
      else if (fill_go) vld_q <= vld_q | slot_sel;
      if (fill_go)      ptr_q <= ptr_d;
    end
  end

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  a_r9_flush_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(ptr_q));

endmodule

// File: rtl/xl_walker.sv
module xl_walker
  import xl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 10,
  parameter int unsigned OUTER_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       ptbr,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic                    req_write,
  output logic [ADDR_W-OFF_W-1:0] lk_vpn,
  input  logic                    lk_hit,
  input  logic [ADDR_W-OFF_W-1:0] lk_pfn,
  input  logic                    lk_wr,
  output logic                    fill_en,
  output logic [ADDR_W-OFF_W-1:0] fill_vpn,
  output logic [ADDR_W-OFF_W-1:0] fill_pfn,
  output logic                    fill_wr,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic                    rsp_fault
);

  localparam int unsigned VPN_W   = ADDR_W - OFF_W;
  localparam int unsigned INNER_W = VPN_W - OUTER_W;

  walk_state_e state_q, state_d;

  logic [ADDR_W-1:0] vaddr_q;
  logic              write_q;
  logic [ADDR_W-1:0] tbase_q, tbase_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              fault_q, fault_d;
  logic              wrbit_q;
  logic              take_req, base_en, res_en;

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;
  logic [ADDR_W-1:0]  outer_addr, inner_addr;
  logic               ent_present, ent_write;
  logic               unused_ent_bits;

  assign outer_idx  = vaddr_q[ADDR_W-1 -: OUTER_W];
  assign inner_idx  = vaddr_q[OFF_W +: INNER_W];
  assign outer_addr = ptbr + ADDR_W'({outer_idx, 2'b00});
  assign inner_addr = tbase_q + ADDR_W'({inner_idx, 2'b00});

  assign ent_present     = mem_rsp_data[PTE_PRESENT_BIT];
  assign ent_write       = mem_rsp_data[PTE_WRITE_BIT];
  assign unused_ent_bits = ^mem_rsp_data[OFF_W-1:2];

  assign lk_vpn = req_vaddr[ADDR_W-1:OFF_W];

  always_comb begin
    state_d  = state_q;
    take_req = 1'b0;
    base_en  = 1'b0;
    res_en   = 1'b0;
    tbase_d  = {mem_rsp_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    paddr_d  = '0;
    fault_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          if (lk_hit) begin
            res_en  = 1'b1;
            fault_d = req_write && !lk_wr;
            paddr_d = fault_d ? '0 : {lk_pfn, req_vaddr[OFF_W-1:0]};
            state_d = ST_RESP;
          end else begin
            state_d = ST_OREQ;
          end
        end
      end
      ST_OREQ: begin
        if (mem_rd_ready) state_d = ST_OWAIT;
      end
      ST_OWAIT: begin
        if (mem_rsp_valid) begin
          if (!ent_present) begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            state_d = ST_RESP;
          end else begin
            base_en = 1'b1;
            state_d = ST_IREQ;
          end
        end
      end
      ST_IREQ: begin
        if (mem_rd_ready) state_d = ST_IWAIT;
      end
      ST_IWAIT: begin
        if (mem_rsp_valid) begin
          res_en = 1'b1;
          if (!ent_present || (write_q && !ent_write)) begin
            fault_d = 1'b1;
            state_d = ST_RESP;
          end else begin
            paddr_d = {mem_rsp_data[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (take_req) begin
      vaddr_q <= req_vaddr;
      write_q <= req_write;
    end
    if (base_en) tbase_q <= tbase_d;
    if (res_en) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
      wrbit_q <= ent_write;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_OREQ) || (state_q == ST_IREQ);
  assign mem_rd_addr  = (state_q == ST_IREQ) ? inner_addr : outer_addr;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign fill_en      = (state_q == ST_FILL);
  assign fill_vpn     = vaddr_q[ADDR_W-1:OFF_W];
  assign fill_pfn     = paddr_q[ADDR_W-1:OFF_W];
  assign fill_wr      = wrbit_q;

  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !rsp_valid));

  a_r12_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  a_r8_fill_then_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rsp_valid && !rsp_fault));

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 10,
  parameter int unsigned OUTER_W   = 12,
  parameter int unsigned TLB_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);

  localparam int unsigned VPN_W = ADDR_W - OFF_W;

  logic [VPN_W-1:0] lk_vpn, lk_pfn, fill_vpn, fill_pfn;
  logic             lk_hit, lk_wr, fill_en, fill_wr;

  xl_tlb #(
    .DEPTH (TLB_DEPTH),
    .VPN_W (VPN_W),
    .PFN_W (VPN_W)
  ) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (lk_vpn),
    .lk_hit   (lk_hit),
    .lk_pfn   (lk_pfn),
    .lk_wr    (lk_wr),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_pfn (fill_pfn),
    .fill_wr  (fill_wr)
  );

  xl_walker #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .OUTER_W (OUTER_W)
  ) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ptbr          (ptbr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .lk_vpn        (lk_vpn),
    .lk_hit        (lk_hit),
    .lk_pfn        (lk_pfn),
    .lk_wr         (lk_wr),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_pfn      (fill_pfn),
    .fill_wr       (fill_wr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
  );

endmodule

// File: tb/test_pt_xlate.sv
module test_pt_xlate;

  localparam logic [31:0] PT_BASE  = 32'h0008_0000;
  localparam logic [31:0] IN_BASE  = 32'h0010_0000;

  logic        clk, rst_n, flush, req_valid, req_write;
  logic [31:0] ptbr, req_vaddr, mem_rsp_data;
  logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] rsp_paddr, mem_rd_addr;

  int n_chk, n_fail;

  pt_xlate i_pt_xlate (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- table contents, computed ----------------
  function automatic logic [31:0] outer_ent(logic [11:0] o);
    logic [21:0] fr;
    logic        pres;
    pres = (o % 12'd5) != 12'd3;
    fr   = 22'h400 + {8'h00, o, 2'b00};
    return {fr, 8'h00, 1'b0, pres};
  endfunction

  function automatic logic [31:0] inner_ent(logic [11:0] o, logic [9:0] i);
    logic [12:0] s;
    logic [21:0] fr;
    logic        pres, wr;
    s    = {1'b0, o} + {3'b000, i};
    pres = (s % 13'd7) != 13'd0;
    wr   = ~(o[0] ^ i[0]);
    fr   = {o, i} ^ 22'h2A5A5;
    return {fr, 8'h00, wr, pres};
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] rel;
    if (a >= PT_BASE && a < PT_BASE + 32'h4000) begin
      rel = a - PT_BASE;
      return outer_ent(rel[13:2]);
    end
    if (a >= IN_BASE && a < IN_BASE + 32'h100_0000) begin
      rel = a - IN_BASE;
      return inner_ent(rel[23:12], rel[11:2]);
    end
    return 32'hDEAD_BEEF;
  endfunction

  // ---------------- memory responder with random stalls ----------------
  logic [31:0] pend_addr;
  logic        busy;
  int          lat_cnt;
  logic [31:0] rd_log [4];
  int          rd_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy          = 1'b0;
      mem_rd_ready  = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
          busy          = 1'b0;
        end else begin
          lat_cnt--;
        end
      end
      mem_rd_ready = !busy && (($urandom % 3) != 0);
      if (mem_rd_valid && mem_rd_ready) begin
        pend_addr = mem_rd_addr;
        busy      = 1'b1;
        lat_cnt   = $urandom % 3;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
      end
    end
  end

  // ---------------- reference cache model ----------------
  logic        m_vld [8];
  logic [21:0] m_vpn [8];
  logic [21:0] m_pfn [8];
  logic        m_wr  [8];
  int          m_ptr;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < 8; k++) m_vld[k] = 1'b0;
  endtask

  task automatic access(logic [11:0] o, logic [9:0] i, logic [9:0] off, logic wr);
    logic [31:0] oe, ie, exp_pa;
    logic        hit, exp_fault, m_w;
    logic [21:0] m_f;
    int          exp_reads, cyc;
    hit = 1'b0; m_w = 1'b0; m_f = '0;
    for (int k = 0; k < 8; k++)
      if (m_vld[k] && m_vpn[k] == {o, i}) begin hit = 1'b1; m_f = m_pfn[k]; m_w = m_wr[k]; end
    oe = outer_ent(o);
    ie = inner_ent(o, i);
    if (hit) begin
      exp_reads = 0;
      exp_fault = wr && !m_w;
      exp_pa    = exp_fault ? 32'h0 : {m_f, off};
    end else if (!oe[0]) begin
      exp_reads = 1; exp_fault = 1'b1; exp_pa = 32'h0;
    end else begin
      exp_reads = 2;
      exp_fault = !ie[0] || (wr && !ie[1]);
      exp_pa    = exp_fault ? 32'h0 : {ie[31:10], off};
    end
    while (!req_ready) @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_vaddr = {o, i, off};
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk("R11", "ready while busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && cyc < 300) begin @(negedge clk); cyc++; end
    chk("R1", "paddr", rsp_paddr, exp_pa);
    chk(exp_fault ? "R7" : "R1", "fault", {31'd0, rsp_fault}, {31'd0, exp_fault});
    if (hit) begin
      chk("R2", "hit latency", cyc, 1);
      chk("R2", "hit reads", rd_cnt, 0);
    end else begin
      chk(exp_reads == 1 ? "R5" : "R6", "read count", rd_cnt, exp_reads);
      chk("R3", "outer addr", rd_log[0], PT_BASE + {18'd0, o, 2'b00});
      if (exp_reads == 2 && rd_cnt >= 2)
        chk("R4", "inner addr", rd_log[1], IN_BASE + {8'd0, o, 12'd0} + {20'd0, i, 2'b00});
      if (!exp_fault) begin
        m_vld[m_ptr] = 1'b1; m_vpn[m_ptr] = {o, i};
        m_pfn[m_ptr] = ie[31:10]; m_wr[m_ptr] = ie[1];
        m_ptr = (m_ptr + 1) % 8;
      end
    end
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  logic [21:0] pool [12];

  initial begin
    void'($urandom(32'd4242));
    n_chk = 0; n_fail = 0; m_ptr = 0; rd_cnt = 0;
    for (int k = 0; k < 8; k++) m_vld[k] = 1'b0;
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_vaddr = '0; ptbr = PT_BASE;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R13", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R13", "mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "ready after release", {31'd0, req_ready}, 32'd1);

    // R8/R2: walk then hit, writable page
    access(12'd1, 10'd1, 10'h123, 1'b0);
    access(12'd1, 10'd1, 10'h3FF, 1'b0);
    access(12'd1, 10'd1, 10'h000, 1'b1);
    // R7: read-only page cached, then write hits and faults
    access(12'd1, 10'd0, 10'h055, 1'b0);
    access(12'd1, 10'd0, 10'h055, 1'b1);
    // R7/R8: write fault on walk installs nothing, read walks again
    access(12'd1, 10'd2, 10'h010, 1'b1);
    access(12'd1, 10'd2, 10'h010, 1'b0);
    // R5: missing first-level entry, twice
    access(12'd3, 10'd4, 10'h001, 1'b0);
    access(12'd3, 10'd4, 10'h001, 1'b0);
    // R6: missing second-level entry
    access(12'd1, 10'd6, 10'h002, 1'b0);
    // R10: cached page misses after flush
    access(12'd1, 10'd1, 10'h100, 1'b0);
    do_flush();
    access(12'd1, 10'd1, 10'h100, 1'b0);
    // R9: fill 9 distinct pages, oldest is evicted
    do_flush();
    access(12'd2, 10'd1, 10'h0, 1'b0);
    access(12'd2, 10'd2, 10'h0, 1'b0);
    access(12'd2, 10'd3, 10'h0, 1'b0);
    access(12'd2, 10'd4, 10'h0, 1'b0);
    access(12'd2, 10'd6, 10'h0, 1'b0);
    access(12'd2, 10'd7, 10'h0, 1'b0);
    access(12'd2, 10'd8, 10'h0, 1'b0);
    access(12'd2, 10'd9, 10'h0, 1'b0);
    access(12'd2, 10'd10, 10'h0, 1'b0);
    access(12'd2, 10'd1, 10'h7, 1'b0);
    access(12'd2, 10'd10, 10'h7, 1'b0);

    // R12 and mixed traffic: random pages with random stalls
    for (int k = 0; k < 12; k++) pool[k] = {12'($urandom % 10), 10'($urandom % 16)};
    for (int n = 0; n < 400; n++) begin
      logic [21:0] v;
      v = pool[$urandom % 12];
      if (($urandom % 40) == 0) do_flush();
      access(v[21:10], v[9:0], 10'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule